// File: doc/BRIEF.md
# Serial wire debug target responder

This block is the target end of a two-wire debug link. It runs on the serial clock that the host supplies. It watches the shared data line for a request. A request is eight bits sent least significant bit first. The block checks the request's framing and parity. It then answers with a three-bit acknowledge, and on a successful access it either returns a 32-bit word or takes one in. Every word moves LSB first and is followed by an even-parity bit. The line is left undriven for one bit at each point where the driver changes.

Requests go to a small test register file of two banks with four words each. The file stands in for the real debug and access registers. Inside the block, the protocol engine and the register file talk over a valid/ready access handshake. The engine holds `acc_valid` high for the single turnaround bit that follows a good request. The file answers in that same bit with `acc_ready` and `acc_fault`. Back-pressure is never queued. If the file is not ready, the engine sends a WAIT acknowledge, drops the access, and leaves the retry to the host. Write data is committed in one strobe, and only after its parity checks. Two plain control pins, `bank_stall` and `bank_err`, make the test file report not-ready or an error.

Top module: `swd_target`

## Requirements
- R1: While reset is applied and after it is released, `swdio_oe` is low. Each word resets to 0x5EED0000 + 4*bank + slot, where bank 0 is the debug bank, bank 1 is the access bank, and slot is the two-bit address.
- R2: A request is sent in this wire order: start=1, bank select, read flag (1=read), address bit 0, address bit 1, parity, stop=0, park. The parity makes the four bits from bank select to address bit 1 even. The park bit is sampled and ignored. A well-formed request is answered.
- R3: If the stop bit of a request is 1, the block never drives the line, and it goes back to looking for a start bit. A later good request is answered normally.
- R4: If the parity bit of a request is wrong, the block never drives the line, and no register changes.
- R5: Exactly one undriven bit follows the park bit. The acknowledge starts in the second bit after park.
- R6: The acknowledge is sent in wire order 1,0,0 for OK, 0,1,0 for WAIT and 0,0,1 for FAULT. FAULT wins when `bank_err` is high. Otherwise WAIT is sent when `bank_stall` is high.
- R7: After an OK on a read, the block drives 32 data bits LSB first and then their even-parity bit. It then releases the line for one bit.
- R8: After an OK on a write, one undriven bit passes. Then 32 data bits and a parity bit are sampled, and the word is stored if the parity is even.
- R9: A write whose data parity is wrong is thrown away, and the register keeps its old value.
- R10: After WAIT or FAULT there is no data phase. The line is released, and no register changes.
- R11: `swdio_oe` is high only during the acknowledge bits and the read-data bits.
- R12: The bank select bit and the two address bits pick one of eight separate words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the host. The line is sampled on its rising edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| swdio_in | input | 1 | Data line as seen at the pad. It reads 1 when nobody drives it. |
| swdio_out | output | 1 | Value the target puts on the line |
| swdio_oe | output | 1 | Target drive enable for the line |
| bank_stall | input | 1 | Makes the test register file report not-ready (WAIT) |
| bank_err | input | 1 | Makes the test register file report an error (FAULT) |

## Verification
Reads of all eight reset values check that the bank select and the address bits each reach a separate word and that their order on the wire is right. Written words of all zeros, all ones, and single bits at either end check the shift direction and the parity sense. A wrong parity bit turns an even result into an odd one, so a swapped parity sense shows up. Requests with a bad stop bit or a bad parity, writes with bad data parity, and accesses under stall, error, or both, are each followed by a read-back. These separate discarded traffic from committed traffic and show the acknowledge priority. Every bit of every transfer is checked for drive enable, so a missing or extra turnaround is caught.

// File: rtl/swd_pkg.sv
package swd_pkg;

  // bits after the start bit: bank, read, a0, a1, parity, stop, park
  localparam int unsigned REQ_BITS = 7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_TRNA,
    S_ACK,
    S_RD,
    S_TRNW,
    S_WR,
    S_TRNE
  } swd_state_e;

  typedef struct packed {
    logic       ap;
    logic       rd;
    logic [1:0] slot;
  } swd_acc_t;

  // acknowledge codes, bit 0 leaves first
  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

endpackage

// File: rtl/swd_req_check.sv
module swd_req_check
  import swd_pkg::*;
(
  input  logic [REQ_BITS-2:0] frame,    // bits 1..6 of the request, bit 1 at index 0
  output logic                frame_ok,
  output swd_acc_t            frame_acc
);

  logic par_even;
  logic stop_low;

  always_comb begin
    frame_acc.ap   = frame[0];
    frame_acc.rd   = frame[1];
    frame_acc.slot = frame[3:2];
    par_even       = (frame[4] == ^frame[3:0]);
    stop_low       = !frame[5];
    frame_ok       = par_even && stop_low;
  end

endmodule

// File: rtl/swd_test_bank.sv
module swd_test_bank
  import swd_pkg::*;
#(
  parameter int unsigned          DW       = 32,
  parameter logic [DW-1:0]        RST_BASE = 32'h5EED_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          err,
  input  logic          acc_valid,
  input  swd_acc_t      acc,
  output logic          acc_ready,
  output logic          acc_fault,
  output logic [DW-1:0] acc_rdata,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data
);

  localparam int unsigned IW    = 1 + $bits(acc.slot);
  localparam int unsigned NWORD = 1 << IW;

  logic [IW-1:0] idx;
  logic [DW-1:0] mem [NWORD];

  assign idx       = {acc.ap, acc.slot};
  assign acc_ready = !stall;
  assign acc_fault = err;
  assign acc_rdata = mem[idx];

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[w] <= RST_BASE + DW'(w);
      else if (wr_valid && idx == IW'(w))
        mem[w] <= wr_data;
    end
  end

  // R8
  wr_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !acc.rd);

  // R10
  no_commit_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !wr_valid);

endmodule

// File: rtl/swd_engine.sv
module swd_engine
  import swd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_in,
  output logic          line_out,
  output logic          line_oe,
  output logic          acc_valid,
  output swd_acc_t      acc,
  input  logic          acc_ready,
  input  logic          acc_fault,
  input  logic [DW-1:0] acc_rdata,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data
);

  localparam int unsigned CW        = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_REQ  = CW'(REQ_BITS - 1);
  localparam logic [CW-1:0] LAST_ACK  = CW'(2);
  localparam logic [CW-1:0] LAST_DATA = CW'(DW);

  swd_state_e          st;
  logic [CW-1:0]       cnt;
  logic [REQ_BITS-2:0] req_sh;
  swd_acc_t            req_q;
  logic [2:0]          ack_q;
  logic [2:0]          ack_next;
  logic [DW-1:0]       rd_sh;
  logic                rd_par;
  logic [DW-1:0]       wr_sh;
  logic                frame_ok;
  swd_acc_t            frame_acc;

  swd_req_check u_chk (
    .frame     (req_sh),
    .frame_ok  (frame_ok),
    .frame_acc (frame_acc)
  );

  // error outranks back-pressure
  always_comb begin
    if (acc_fault)       ack_next = ACK_FAULT;
    else if (!acc_ready) ack_next = ACK_WAIT;
    else                 ack_next = ACK_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      req_sh <= '0;
      req_q  <= '0;
      ack_q  <= '0;
      rd_sh  <= '0;
      rd_par <= 1'b0;
      wr_sh  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (line_in) begin
            st  <= S_REQ;
            cnt <= '0;
          end
        end
        S_REQ: begin
          if (cnt != LAST_REQ) begin
            req_sh <= {line_in, req_sh[REQ_BITS-2:1]};
            cnt    <= cnt + 1'b1;
          end else if (frame_ok) begin
            req_q <= frame_acc;
            st    <= S_TRNA;
          end else begin
            st <= S_IDLE;
          end
        end
        S_TRNA: begin
          ack_q  <= ack_next;
          rd_sh  <= acc_rdata;
          rd_par <= ^acc_rdata;
          cnt    <= '0;
          st     <= S_ACK;
        end
        S_ACK: begin
          if (cnt != LAST_ACK) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (ack_q != ACK_OK) st <= S_TRNE;
            else if (req_q.rd)   st <= S_RD;
            else                 st <= S_TRNW;
          end
        end
        S_RD: begin
          if (cnt != LAST_DATA) begin
            rd_sh <= rd_sh >> 1;
            cnt   <= cnt + 1'b1;
          end else begin
            st <= S_TRNE;
          end
        end
        S_TRNW: begin
          cnt <= '0;
          st  <= S_WR;
        end
        S_WR: begin
          if (cnt != LAST_DATA) begin
            wr_sh <= {line_in, wr_sh[DW-1:1]};
            cnt   <= cnt + 1'b1;
          end else begin
            st <= S_IDLE;
          end
        end
        S_TRNE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    line_oe  = (st == S_ACK) || (st == S_RD);
    line_out = 1'b0;
    if (st == S_ACK)
      line_out = ack_q[cnt[1:0]];
    else if (st == S_RD)
      line_out = (cnt == LAST_DATA) ? rd_par : rd_sh[0];
  end

  assign acc_valid = (st == S_TRNA);
  assign acc       = req_q;
  assign wr_data   = wr_sh;
  assign wr_valid  = (st == S_WR) && (cnt == LAST_DATA) && (line_in == ^wr_sh);

  // R5
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(st) == S_TRNA);

  // R6
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK) |-> $countones(ack_q) == 1);

  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && cnt == LAST_DATA) |=> !line_oe);

  // R8
  commit_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ack_q == ACK_OK);

  // R3 and R4
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REQ && cnt == LAST_REQ && !frame_ok) |=> (st == S_IDLE && !line_oe));

endmodule

// File: rtl/swd_target.sv
module swd_target
  import swd_pkg::*;
#(
  parameter int unsigned          DATA_W   = 32,
  parameter logic [DATA_W-1:0]    RST_BASE = 32'h5EED_0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic swdio_in,
  output logic swdio_out,
  output logic swdio_oe,
  input  logic bank_stall,
  input  logic bank_err
);

  logic              acc_valid;
  swd_acc_t          acc;
  logic              acc_ready;
  logic              acc_fault;
  logic [DATA_W-1:0] acc_rdata;
  logic              wr_valid;
  logic [DATA_W-1:0] wr_data;

  swd_engine #(.DW(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (swdio_in),
    .line_out  (swdio_out),
    .line_oe   (swdio_oe),
    .acc_valid (acc_valid),
    .acc       (acc),
    .acc_ready (acc_ready),
    .acc_fault (acc_fault),
    .acc_rdata (acc_rdata),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data)
  );

  swd_test_bank #(.DW(DATA_W), .RST_BASE(RST_BASE)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (bank_stall),
    .err       (bank_err),
    .acc_valid (acc_valid),
    .acc       (acc),
    .acc_ready (acc_ready),
    .acc_fault (acc_fault),
    .acc_rdata (acc_rdata),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data)
  );

endmodule

// File: tb/sim_swd_target.sv
`timescale 1ns/1ps
module sim_swd_target;

  localparam logic [2:0]  OK    = 3'b001;
  localparam logic [2:0]  WAIT  = 3'b010;
  localparam logic [2:0]  FAULT = 3'b100;
  localparam logic [31:0] BASE  = 32'h5EED_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swdio_in = 1'b0;
  logic bank_stall = 1'b0;
  logic bank_err = 1'b0;
  logic swdio_out;
  logic swdio_oe;
  int total = 0;
  int bad = 0;
  logic [31:0] model [8];

  swd_target u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .swdio_in   (swdio_in),
    .swdio_out  (swdio_out),
    .swdio_oe   (swdio_oe),
    .bank_stall (bank_stall),
    .bank_err   (bank_err)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one bit window: observe the target, then drive the host side
  task automatic cyc(input logic d, output logic oe, output logic o);
    @(negedge clk);
    oe = swdio_oe;
    o  = swdio_out;
    swdio_in = d;
  endtask

  task automatic idle(input int n, inout int stray);
    logic oe, o;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, oe, o);
      if (oe) stray++;
    end
  endtask

  task automatic send_req(input logic ap, input logic rnw, input logic [1:0] a,
                          input logic badpar, input logic badstop, inout int stray);
    logic [7:0] f;
    logic oe, o;
    f = {1'b1, badstop, (ap ^ rnw ^ a[0] ^ a[1]) ^ badpar, a[1], a[0], rnw, ap, 1'b1};
    for (int i = 0; i < 8; i++) begin
      cyc(f[i], oe, o);
      if (oe) stray++;
    end
  endtask

  task automatic swd_read(input logic ap, input logic [1:0] a, input logic [2:0] exp_ack,
                          input logic [31:0] exp_d, input string tag);
    logic oe, o, p;
    logic [2:0] ack;
    logic [31:0] d;
    int stray = 0;
    int miss = 0;
    send_req(ap, 1'b1, a, 1'b0, 1'b0, stray);
    cyc(1'b1, oe, o);
    check(!oe, "R5", "turnaround after request driven", 36'(oe), 36'(0));
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, oe, o);
      if (!oe) miss++;
      ack[i] = o;
    end
    check(ack == exp_ack, tag, "read ack", 36'(ack), 36'(exp_ack));
    if (ack == OK) begin
      for (int i = 0; i < 32; i++) begin
        cyc(1'b1, oe, o);
        if (!oe) miss++;
        d[i] = o;
      end
      cyc(1'b1, oe, o);
      if (!oe) miss++;
      p = o;
      if (exp_ack == OK) begin
        check(d == exp_d, tag, "read data", 36'(d), 36'(exp_d));
        check(p == ^exp_d, "R7", "read parity", 36'(p), 36'(^exp_d));
      end
    end
    cyc(1'b1, oe, o);
    check(!oe, "R7", "release after data/ack", 36'(oe), 36'(0));
    idle(2, stray);
    check(stray == 0, "R11", "driven outside ack/read data", 36'(stray), 36'(0));
    check(miss == 0, "R11", "released inside ack/read data", 36'(miss), 36'(0));
  endtask

  task automatic swd_write(input logic ap, input logic [1:0] a, input logic [31:0] d,
                           input logic badpar, input logic [2:0] exp_ack, input string tag);
    logic oe, o;
    logic [2:0] ack;
    int stray = 0;
    int miss = 0;
    send_req(ap, 1'b0, a, 1'b0, 1'b0, stray);
    cyc(1'b1, oe, o);
    if (oe) stray++;
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, oe, o);
      if (!oe) miss++;
      ack[i] = o;
    end
    check(ack == exp_ack, tag, "write ack", 36'(ack), 36'(exp_ack));
    cyc(1'b1, oe, o);
    check(!oe, "R8", "turnaround after ack driven", 36'(oe), 36'(0));
    if (ack == OK) begin
      for (int i = 0; i < 32; i++) begin
        cyc(d[i], oe, o);
        if (oe) stray++;
      end
      cyc((^d) ^ badpar, oe, o);
      if (oe) stray++;
    end
    idle(2, stray);
    check(stray == 0, "R11", "driven during write", 36'(stray), 36'(0));
    check(miss == 0, "R11", "ack not driven", 36'(miss), 36'(0));
  endtask

  task automatic t_reset;
    check(!swdio_oe, "R1", "oe after reset", 36'(swdio_oe), 36'(0));
    for (int w = 0; w < 8; w++) begin
      model[w] = BASE + 32'(w);
      swd_read(w[2], w[1:0], OK, model[w], "R1/R2/R12");
    end
  endtask

  task automatic t_write_back;
    swd_write(1'b0, 2'd1, 32'h1234_5678, 1'b0, OK, "R8");
    model[1] = 32'h1234_5678;
    swd_write(1'b1, 2'd1, 32'hCAFE_F00D, 1'b0, OK, "R8");
    model[5] = 32'hCAFE_F00D;
    swd_read(1'b0, 2'd1, OK, model[1], "R8/R12");
    swd_read(1'b1, 2'd1, OK, model[5], "R8/R12");
    swd_read(1'b1, 2'd2, OK, model[6], "R12");
  endtask

  task automatic t_patterns;
    logic [31:0] pats [4];
    pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001};
    foreach (pats[i]) begin
      swd_write(1'b1, 2'd3, pats[i], 1'b0, OK, "R8");
      model[7] = pats[i];
      swd_read(1'b1, 2'd3, OK, model[7], "R7");
    end
  endtask

  task automatic t_bad_wpar;
    swd_write(1'b0, 2'd2, 32'hDEAD_BEEF, 1'b1, OK, "R9");
    swd_read(1'b0, 2'd2, OK, model[2], "R9");
  endtask

  task automatic t_wait;
    bank_stall = 1'b1;
    swd_write(1'b1, 2'd0, 32'h0BAD_0BAD, 1'b0, WAIT, "R6");
    swd_read(1'b1, 2'd0, WAIT, 32'h0, "R10");
    bank_stall = 1'b0;
    swd_read(1'b1, 2'd0, OK, model[4], "R10");
  endtask

  task automatic t_fault;
    bank_err = 1'b1;
    bank_stall = 1'b1;
    swd_read(1'b0, 2'd3, FAULT, 32'h0, "R6");
    bank_stall = 1'b0;
    swd_write(1'b0, 2'd3, 32'h7777_0000, 1'b0, FAULT, "R6");
    bank_err = 1'b0;
    swd_read(1'b0, 2'd3, OK, model[3], "R10");
  endtask

  task automatic t_bad_frames;
    int stray = 0;
    send_req(1'b0, 1'b1, 2'd0, 1'b0, 1'b1, stray);
    idle(40, stray);
    check(stray == 0, "R3", "response to bad stop", 36'(stray), 36'(0));
    swd_read(1'b0, 2'd0, OK, model[0], "R3");
    stray = 0;
    send_req(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, stray);
    idle(40, stray);
    check(stray == 0, "R4", "response to bad parity", 36'(stray), 36'(0));
    swd_read(1'b0, 2'd0, OK, model[0], "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!swdio_oe, "R1", "oe during reset", 36'(swdio_oe), 36'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_back();
    t_patterns();
    t_bad_wpar();
    t_wait();
    t_fault();
    t_bad_frames();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule